// File: doc/BRIEF.md
# MDIO Management Register Bank for a 10/100 PHY

This block is the management slave of a 10/100 Ethernet PHY. It is clocked by the serial management clock, MDC. It decodes clause-22 style read and write frames on MDIO. It returns read data on the same wire through a separate output and output-enable pair, which the pad ring combines into the bidirectional pin. Behind the frame decoder sit ten 16-bit registers:

- control, status, two identifier words, advertisement, link-partner ability and an expansion word;
- a vendor scratch word, an interrupt enable/event word and a diagnostic word.

Three strap pins name the technologies the PHY may run. The straps bound which speed the control register can select and set the ability bits reported in status. The control bits leave the block as plain level outputs. Link, receive-lock, cycle-slip and event signals come in as plain level inputs. Every interface here is a bare control or status pin or the one-bit serial management line, so no valid/ready handshake and no back-pressure exist.

Top module: `mdio_regfile`

## Requirements
- R1: A frame is recognised only when at least 32 consecutive MDIO ones are followed by the start pair 0 then 1. A frame with a shorter run of ones has no effect.
- R2: After the start pair come a 2-bit opcode (10 = read, 01 = write), a 5-bit PHY address and a 5-bit register address, all MSB first. The frame is served when the PHY address equals `phy_addr` or equals 00000. For any other address, `mdio_oe` stays low and nothing is written.
- R3: On a read, `mdio_oe` is low for the first turnaround bit. The block then drives 0 for the second turnaround bit and 16 data bits MSB first, each updated on a rising MDC edge. `mdio_oe` returns low on the edge after the last data bit.
- R4: The implemented addresses are 0, 1, 2, 3, 4, 5, 6, 16, 17 and 18. Any other address reads 0x0000 and ignores writes. Address 5 reads `lp_ability`, address 6 reads 0x0000, and address 16 is a read/write word that resets to 0.
- R5: Control word (address 0) layout: bit 14 loopback, bit 13 speed (1 = 100 Mb/s), bit 12 auto-negotiation enable, bit 11 power-down, bit 10 isolate, bit 8 full duplex; all other bits read 0. Straps: bit 0 allows 10 Mb/s, bit 1 allows 100 Mb/s, bit 2 allows full duplex. At reset, speed = strap bit 1, duplex = strap bit 2 and auto-negotiation = 1. A write changes the speed bit only when the strap allows the new speed.
- R6: `speed_100` equals `an_speed_100` while auto-negotiation is enabled. Otherwise it equals control bit 13.
- R7: Status (address 1) reads ability bits [15:11] = {0, s1&s2, s1, s0&s2, s0} from the straps alone. Bit 3 and bit 0 read 1, bit 2 reads `link_up`, and all other bits read 0. Writes to address 0 do not alter these bits.
- R8: Address 2 reads 0x0300. Address 3 reads {6 OUI bits (default 0x2B), model 0x14, revision (default 0x2)} = 0xAD42.
- R9: Advertisement (address 4) resets to 0x01E1. Bits [14:0] are writable, and bit 15 always reads 0.
- R10: Diagnostic (address 18) reads bit 2 = `full_duplex`, bit 1 = `speed_100`, and bit 0 = lock. A `cycle_slip` pulse forces the lock bit to 0 until address 18 is next read, even if `rx_lock` is 1. After that read, the lock bit follows `rx_lock` again.
- R11: While isolate is set, `mii_oe` is 0 and management frames are still served.
- R12: Address 17 holds enables in [15:8] (writable) and events in [7:0]. An `event_in` pulse sets its bit. `irq` is 1 when any event bit and its enable are both set. A read of address 17 returns the events and clears them.
- R13: The loopback, auto-negotiation, power-down, isolate and duplex outputs follow their control bits from the edge that takes in the last data bit of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_in | input | 1 | Serial management data from the pin |
| mdio_out | output | 1 | Serial read data toward the pin |
| mdio_oe | output | 1 | Drive enable for mdio_out |
| phy_addr | input | 5 | This PHY's management address |
| tech_strap | input | 3 | Allowed technologies: [0] 10M, [1] 100M, [2] full duplex |
| link_up | input | 1 | Current link state |
| rx_lock | input | 1 | Receive clock recovery locked |
| cycle_slip | input | 1 | Pulse: receive recovery slipped a cycle |
| an_speed_100 | input | 1 | Speed resolved by auto-negotiation |
| lp_ability | input | 16 | Link partner ability word |
| event_in | input | 8 | Interrupt event pulses |
| loopback | output | 1 | Loopback enable |
| speed_100 | output | 1 | Speed in use, 1 = 100 Mb/s |
| full_duplex | output | 1 | Duplex mode |
| an_enable | output | 1 | Auto-negotiation enable |
| power_down | output | 1 | Power-down request |
| isolate | output | 1 | Isolate request |
| mii_oe | output | 1 | Output enable for the MII data pins |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives MDIO and samples every output on the falling MDC edge. Each sample therefore shows the state left by the rising edge just before it. Counting from the rising edge that takes in the last register-address bit:

- the first sample must show `mdio_oe` low;
- the next sample shows a driven 0;
- the 16 samples after that carry the data bits;
- the sample after those shows `mdio_oe` low again.

Write side effects are checked one falling edge after the edge that takes in the final data bit. Event, slip and interrupt results are checked one falling edge after the rising edge that captured the pulse.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int REG_W = 16;
  localparam int ADR_W = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_HDR, S_RTA, S_RDATA, S_WR
  } fr_state_t;

  localparam logic [ADR_W-1:0] A_CTRL  = 5'd0;
  localparam logic [ADR_W-1:0] A_STAT  = 5'd1;
  localparam logic [ADR_W-1:0] A_ID_HI = 5'd2;
  localparam logic [ADR_W-1:0] A_ID_LO = 5'd3;
  localparam logic [ADR_W-1:0] A_ADV   = 5'd4;
  localparam logic [ADR_W-1:0] A_LPA   = 5'd5;
  localparam logic [ADR_W-1:0] A_EXP   = 5'd6;
  localparam logic [ADR_W-1:0] A_VEND  = 5'd16;
  localparam logic [ADR_W-1:0] A_IRQ   = 5'd17;
  localparam logic [ADR_W-1:0] A_DIAG  = 5'd18;
endpackage

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_MIN = 32,
  parameter int AW      = 5,
  parameter int DW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mdio_in,
  input  logic [AW-1:0] phy_addr,
  input  logic [DW-1:0] rd_data,
  output logic          mdio_out,
  output logic          mdio_oe,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] wr_data
);
  localparam int HB   = 2 + 2*AW;
  localparam int MAXC = (DW + 2 > HB) ? DW + 2 : HB;
  localparam int NW   = $clog2(MAXC + 1);
  localparam int CW   = $clog2(PRE_MIN + 1);

  fr_state_t     st;
  logic [CW-1:0] ones_q;
  logic [NW-1:0] cnt_q;
  logic [HB-1:0] hdr_q, hdr_nx;
  logic [AW-1:0] ra_q, pa, ra;
  logic [DW-1:0] sh_q;
  logic [1:0]    op;
  logic          hit, hdr_last;

  always_comb begin
    hdr_nx   = {hdr_q[HB-2:0], mdio_in};
    op       = hdr_nx[HB-1 -: 2];
    pa       = hdr_nx[2*AW-1 -: AW];
    ra       = hdr_nx[AW-1:0];
    hit      = (pa == phy_addr) || (pa == '0);
    hdr_last = (st == S_HDR) && (cnt_q == NW'(HB - 1));
  end

  assign rd_stb   = hdr_last && hit && (op == 2'b10);
  assign wr_stb   = (st == S_WR) && (cnt_q == NW'(DW + 1));
  assign reg_addr = (st == S_HDR) ? ra : ra_q;
  assign wr_data  = {sh_q[DW-2:0], mdio_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ones_q   <= '0;
      cnt_q    <= '0;
      hdr_q    <= '0;
      ra_q     <= '0;
      sh_q     <= '0;
      mdio_out <= 1'b0;
      mdio_oe  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (mdio_in) begin
            if (ones_q != CW'(PRE_MIN)) ones_q <= ones_q + 1'b1;
          end else begin
            if (ones_q == CW'(PRE_MIN)) st <= S_START;
            ones_q <= '0;
          end
        end
        S_START: begin
          cnt_q <= '0;
          st    <= mdio_in ? S_HDR : S_IDLE;
        end
        S_HDR: begin
          hdr_q <= hdr_nx;
          cnt_q <= cnt_q + 1'b1;
          if (hdr_last) begin
            cnt_q <= '0;
            ra_q  <= ra;
            if (hit && op == 2'b10) begin
              st   <= S_RTA;
              sh_q <= rd_data;
            end else if (hit && op == 2'b01) begin
              st <= S_WR;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_RTA: begin
          mdio_oe  <= 1'b1;
          mdio_out <= 1'b0;
          cnt_q    <= '0;
          st       <= S_RDATA;
        end
        S_RDATA: begin
          if (cnt_q == NW'(DW)) begin
            mdio_oe  <= 1'b0;
            mdio_out <= 1'b0;
            st       <= S_IDLE;
          end else begin
            mdio_out <= sh_q[DW-1];
            sh_q     <= {sh_q[DW-2:0], 1'b0};
            cnt_q    <= cnt_q + 1'b1;
          end
        end
        S_WR: begin
          sh_q  <= {sh_q[DW-2:0], mdio_in};
          cnt_q <= cnt_q + 1'b1;
          if (wr_stb) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  short_preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !mdio_in && ones_q < CW'(PRE_MIN)) |=> (st == S_IDLE));

  // R3
  ta_drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> (!mdio_out && $past(st) == S_RTA));

  // R2
  wr_addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (hdr_q[2*AW-1 -: AW] == phy_addr || hdr_q[2*AW-1 -: AW] == '0));
endmodule

// File: rtl/mdio_event_unit.sv
module mdio_event_unit #(
  parameter int NEV = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] event_in,
  input  logic           wr_en,
  input  logic [NEV-1:0] en_wdata,
  input  logic           rd_clr,
  output logic [2*NEV-1:0] reg_word,
  output logic           irq
);
  logic [NEV-1:0] ev_q, en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= en_wdata;
  end

  for (genvar i = 0; i < NEV; i++) begin : g_ev
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           ev_q[i] <= 1'b0;
      else if (rd_clr)      ev_q[i] <= event_in[i];
      else if (event_in[i]) ev_q[i] <= 1'b1;
    end

    // R12
    ev_clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ev_q[i]) |-> $past(rd_clr));
  end

  assign reg_word = {en_q, ev_q};
  assign irq      = |(ev_q & en_q);
endmodule

// File: rtl/mdio_csr_bank.sv
module mdio_csr_bank
  import mdio_mgmt_pkg::*;
#(
  parameter logic [15:0] ID_HI  = 16'h0300,
  parameter logic [5:0]  OUI_LO = 6'h2B,
  parameter logic [5:0]  MODEL  = 6'h14,
  parameter logic [3:0]  REV    = 4'h2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_stb,
  input  logic             wr_stb,
  input  logic [ADR_W-1:0] addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [2:0]       tech_strap,
  input  logic             link_up,
  input  logic             rx_lock,
  input  logic             cycle_slip,
  input  logic             an_speed_100,
  input  logic [REG_W-1:0] lp_ability,
  input  logic [REG_W-1:0] irq_word,
  output logic [REG_W-1:0] rd_data,
  output logic             loopback,
  output logic             speed_100,
  output logic             full_duplex,
  output logic             an_enable,
  output logic             power_down,
  output logic             isolate
);
  logic        lpbk_q, spd_q, an_q, pd_q, iso_q, dup_q, hold_q;
  logic [14:0] adv_q;
  logic [REG_W-1:0] vend_q;
  logic [4:0]  ability;
  logic        spd_ok, lock_view, diag_rd;
  logic        unused_wbits;

  assign unused_wbits = ^{wr_data[15], wr_data[9], wr_data[7:0]};
  assign ability   = {1'b0, tech_strap[1] & tech_strap[2], tech_strap[1],
                      tech_strap[0] & tech_strap[2], tech_strap[0]};
  assign spd_ok    = wr_data[13] ? tech_strap[1] : tech_strap[0];
  assign diag_rd   = rd_stb && (addr == A_DIAG);
  assign lock_view = rx_lock && !hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lpbk_q <= 1'b0;
      spd_q  <= tech_strap[1];
      an_q   <= 1'b1;
      pd_q   <= 1'b0;
      iso_q  <= 1'b0;
      dup_q  <= tech_strap[2];
      adv_q  <= 15'h01E1;
      vend_q <= '0;
    end else if (wr_stb) begin
      case (addr)
        A_CTRL: begin
          lpbk_q <= wr_data[14];
          if (spd_ok) spd_q <= wr_data[13];
          an_q   <= wr_data[12];
          pd_q   <= wr_data[11];
          iso_q  <= wr_data[10];
          dup_q  <= wr_data[8];
        end
        A_ADV:   adv_q  <= wr_data[14:0];
        A_VEND:  vend_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hold_q <= 1'b0;
    else if (cycle_slip) hold_q <= 1'b1;
    else if (diag_rd)    hold_q <= 1'b0;
  end

  assign loopback    = lpbk_q;
  assign an_enable   = an_q;
  assign power_down  = pd_q;
  assign isolate     = iso_q;
  assign full_duplex = dup_q;
  assign speed_100   = an_q ? an_speed_100 : spd_q;

  always_comb begin
    case (addr)
      A_CTRL:  rd_data = {1'b0, lpbk_q, spd_q, an_q, pd_q, iso_q, 1'b0, dup_q, 8'h00};
      A_STAT:  rd_data = {ability, 7'b0, 1'b1, link_up, 1'b0, 1'b1};
      A_ID_HI: rd_data = ID_HI;
      A_ID_LO: rd_data = {OUI_LO, MODEL, REV};
      A_ADV:   rd_data = {1'b0, adv_q};
      A_LPA:   rd_data = lp_ability;
      A_EXP:   rd_data = '0;
      A_VEND:  rd_data = vend_q;
      A_IRQ:   rd_data = irq_word;
      A_DIAG:  rd_data = {13'b0, dup_q, speed_100, lock_view};
      default: rd_data = '0;
    endcase
  end

  // R5
  spd_rise_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spd_q) |-> tech_strap[1]);

  // R5
  spd_fall_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spd_q) |-> tech_strap[0]);

  // R10
  lock_hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> $past(diag_rd));
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_MIN = 32
) (
  input  logic        mdc,
  input  logic        rst_n,
  input  logic        mdio_in,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic [4:0]  phy_addr,
  input  logic [2:0]  tech_strap,
  input  logic        link_up,
  input  logic        rx_lock,
  input  logic        cycle_slip,
  input  logic        an_speed_100,
  input  logic [15:0] lp_ability,
  input  logic [7:0]  event_in,
  output logic        loopback,
  output logic        speed_100,
  output logic        full_duplex,
  output logic        an_enable,
  output logic        power_down,
  output logic        isolate,
  output logic        mii_oe,
  output logic        irq
);
  localparam int NEV = REG_W / 2;

  logic             rd_stb, wr_stb;
  logic [ADR_W-1:0] reg_addr;
  logic [REG_W-1:0] wr_data, rd_data, irq_word;

  mdio_frame_engine #(.PRE_MIN(PRE_MIN), .AW(ADR_W), .DW(REG_W)) u_frame (
    .clk(mdc), .rst_n(rst_n), .mdio_in(mdio_in), .phy_addr(phy_addr),
    .rd_data(rd_data), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .reg_addr(reg_addr), .wr_data(wr_data)
  );

  mdio_event_unit #(.NEV(NEV)) u_event (
    .clk(mdc), .rst_n(rst_n), .event_in(event_in),
    .wr_en(wr_stb && reg_addr == A_IRQ), .en_wdata(wr_data[REG_W-1:NEV]),
    .rd_clr(rd_stb && reg_addr == A_IRQ), .reg_word(irq_word), .irq(irq)
  );

  mdio_csr_bank u_csr (
    .clk(mdc), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .addr(reg_addr), .wr_data(wr_data), .tech_strap(tech_strap),
    .link_up(link_up), .rx_lock(rx_lock), .cycle_slip(cycle_slip),
    .an_speed_100(an_speed_100), .lp_ability(lp_ability), .irq_word(irq_word),
    .rd_data(rd_data), .loopback(loopback), .speed_100(speed_100),
    .full_duplex(full_duplex), .an_enable(an_enable),
    .power_down(power_down), .isolate(isolate)
  );

  assign mii_oe = !isolate;

  // R11
  rd_served_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    rd_stb |-> ##2 mdio_oe);
endmodule

// File: tb/test_mdio_regfile.sv
module test_mdio_regfile;
  localparam time TCLK = 10ns;
  localparam logic [4:0] PHY = 5'h0B;

  logic mdc = 1'b0, rst_n = 1'b0, mdio_in = 1'b1;
  logic mdio_out, mdio_oe;
  logic [4:0] phy_addr = PHY;
  logic [2:0] tech_strap = 3'b111;
  logic link_up = 1'b1, rx_lock = 1'b1, cycle_slip = 1'b0, an_speed_100 = 1'b1;
  logic [15:0] lp_ability = 16'h45E1;
  logic [7:0] event_in = '0;
  logic loopback, speed_100, full_duplex, an_enable, power_down, isolate, mii_oe, irq;

  int n_chk = 0, n_fail = 0;
  logic smp_out, smp_oe;

  always #(TCLK/2) mdc = ~mdc;

  mdio_regfile i_mdio_regfile (
    .mdc(mdc), .rst_n(rst_n), .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .phy_addr(phy_addr), .tech_strap(tech_strap), .link_up(link_up), .rx_lock(rx_lock),
    .cycle_slip(cycle_slip), .an_speed_100(an_speed_100), .lp_ability(lp_ability),
    .event_in(event_in), .loopback(loopback), .speed_100(speed_100),
    .full_duplex(full_duplex), .an_enable(an_enable), .power_down(power_down),
    .isolate(isolate), .mii_oe(mii_oe), .irq(irq)
  );

  function automatic logic [15:0] f_status(input logic [2:0] s, input logic lk);
    return {1'b0, s[1] & s[2], s[1], s[0] & s[2], s[0], 7'b0, 1'b1, lk, 1'b0, 1'b1};
  endfunction
  function automatic logic [15:0] f_ctrl(input logic lp, sp, an, pd, iso, dup);
    return {1'b0, lp, sp, an, pd, iso, 1'b0, dup, 8'h00};
  endfunction
  function automatic logic f_spd(input logic cur, want, input logic [2:0] s);
    return (want ? s[1] : s[0]) ? want : cur;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic b);
    @(negedge mdc);
    smp_out = mdio_out;
    smp_oe  = mdio_oe;
    mdio_in = b;
  endtask

  task automatic send_hdr(input int pre, input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra);
    repeat (pre) tick(1'b1);
    tick(1'b0); tick(1'b1);
    for (int i = 1; i >= 0; i--) tick(op[i]);
    for (int i = 4; i >= 0; i--) tick(pa[i]);
    for (int i = 4; i >= 0; i--) tick(ra[i]);
  endtask

  task automatic mdio_wr(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d, input int pre = 32);
    send_hdr(pre, 2'b01, pa, ra);
    tick(1'b1); tick(1'b0);
    for (int i = 15; i >= 0; i--) tick(d[i]);
    tick(1'b1);
  endtask

  task automatic mdio_rd(input logic [4:0] pa, input logic [4:0] ra,
                         output logic [15:0] d, output logic proto_ok, output logic seen);
    send_hdr(32, 2'b10, pa, ra);
    proto_ok = 1'b1; seen = 1'b0; d = '0;
    tick(1'b1);
    seen |= smp_oe;
    if (smp_oe !== 1'b0) proto_ok = 1'b0;
    tick(1'b1);
    seen |= smp_oe;
    if (smp_oe !== 1'b1 || smp_out !== 1'b0) proto_ok = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      tick(1'b1);
      seen |= smp_oe;
      if (smp_oe !== 1'b1) proto_ok = 1'b0;
      d[i] = smp_out;
    end
    tick(1'b1);
    if (smp_oe !== 1'b0) proto_ok = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] ra, input logic [15:0] exp);
    logic [15:0] d; logic ok, seen;
    mdio_rd(PHY, ra, d, ok, seen);
    chk({tag, " data"}, d, exp);
    chk({tag, " R3 turnaround/release"}, {15'b0, ok}, 16'h1);
  endtask

  task automatic do_reset(input logic [2:0] s);
    rst_n = 1'b0; tech_strap = s;
    repeat (3) @(negedge mdc);
    rst_n = 1'b1;
    @(negedge mdc);
  endtask

  initial begin
    repeat (150000) @(posedge mdc);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] d, exp, rv; logic ok, seen, sp;
    void'($urandom(32'd2024));
    do_reset(3'b111);

    // R13 R5 R6 reset state at the ports
    chk("R13 reset outputs", {9'b0, loopback, an_enable, power_down, isolate, full_duplex, mii_oe, irq},
        {9'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0});
    chk("R6 reset speed follows AN", {15'b0, speed_100}, 16'h1);
    chk("R3 idle no drive", {15'b0, mdio_oe}, 16'h0);
    rd_chk("R5 reset control", 5'd0, f_ctrl(0, 1, 1, 0, 0, 1));
    rd_chk("R7 status", 5'd1, f_status(3'b111, 1'b1));
    rd_chk("R8 id hi", 5'd2, 16'h0300);
    rd_chk("R8 id lo", 5'd3, {6'h2B, 6'h14, 4'h2});
    rd_chk("R9 adv reset", 5'd4, 16'h01E1);
    rd_chk("R4 partner word", 5'd5, 16'h45E1);
    rd_chk("R4 expansion", 5'd6, 16'h0000);
    rd_chk("R4 vendor reset", 5'd16, 16'h0000);

    // R4 unimplemented addresses
    rd_chk("R4 addr7 zero", 5'd7, 16'h0000);
    mdio_wr(PHY, 5'd31, 16'hFFFF);
    rd_chk("R4 addr31 zero", 5'd31, 16'h0000);
    rd_chk("R4 write elsewhere no effect", 5'd16, 16'h0000);

    // R2 broadcast and foreign address
    mdio_wr(5'd0, 5'd16, 16'h1234);
    rd_chk("R2 broadcast write", 5'd16, 16'h1234);
    mdio_wr(5'h05, 5'd16, 16'hBEEF);
    rd_chk("R2 foreign write ignored", 5'd16, 16'h1234);
    mdio_rd(5'h05, 5'd16, d, ok, seen);
    chk("R2 foreign read no drive", {15'b0, seen}, 16'h0);
    mdio_rd(5'd0, 5'd2, d, ok, seen);
    chk("R2 broadcast read", d, 16'h0300);

    // R1 short preamble, then exactly 32 ones
    tick(1'b0);
    mdio_wr(PHY, 5'd16, 16'hAAAA, 20);
    rd_chk("R1 short preamble ignored", 5'd16, 16'h1234);
    tick(1'b0);
    mdio_wr(PHY, 5'd16, 16'h5678, 32);
    rd_chk("R1 exact 32 ones accepted", 5'd16, 16'h5678);

    // R9 next-page bit
    mdio_wr(PHY, 5'd4, 16'hFFFF);
    rd_chk("R9 bit15 stays zero", 5'd4, 16'h7FFF);

    // R9 R4 random writes/readbacks
    for (int k = 0; k < 16; k++) begin
      logic [15:0] rnd; logic pick;
      rnd = 16'($urandom); pick = 1'($urandom);
      mdio_wr(PHY, pick ? 5'd4 : 5'd16, rnd);
      rd_chk(pick ? "R9 random adv" : "R4 random vendor", pick ? 5'd4 : 5'd16,
             pick ? (rnd & 16'h7FFF) : rnd);
    end

    // R13 control outputs
    mdio_wr(PHY, 5'd0, f_ctrl(1, 1, 1, 1, 0, 0));
    chk("R13 outputs after write", {12'b0, loopback, an_enable, power_down, full_duplex}, 16'b1110);
    rd_chk("R7 status unchanged by control write", 5'd1, f_status(3'b111, 1'b1));

    // R6 speed source
    an_speed_100 = 1'b0;
    mdio_wr(PHY, 5'd0, f_ctrl(0, 1, 1, 0, 0, 0));
    @(negedge mdc);
    chk("R6 AN speed wins", {15'b0, speed_100}, 16'h0);
    mdio_wr(PHY, 5'd0, f_ctrl(0, 1, 0, 0, 0, 1));
    chk("R6 manual speed", {15'b0, speed_100}, 16'h1);

    // R11 isolate
    mdio_wr(PHY, 5'd0, f_ctrl(0, 1, 0, 0, 1, 1));
    chk("R11 isolate drops mii_oe", {14'b0, isolate, mii_oe}, 16'b10);
    rd_chk("R11 frames served while isolated", 5'd2, 16'h0300);
    mdio_wr(PHY, 5'd0, f_ctrl(0, 1, 0, 0, 0, 1));
    chk("R11 mii_oe back", {15'b0, mii_oe}, 16'h1);

    // R10 lock latch
    rd_chk("R10 diag locked", 5'd18, {13'b0, 1'b1, 1'b1, 1'b1});
    @(negedge mdc); cycle_slip = 1'b1;
    @(negedge mdc); cycle_slip = 1'b0;
    rd_chk("R10 held low after slip", 5'd18, {13'b0, 1'b1, 1'b1, 1'b0});
    rd_chk("R10 released by read", 5'd18, {13'b0, 1'b1, 1'b1, 1'b1});

    // R12 interrupts
    mdio_wr(PHY, 5'd17, 16'h0300);
    @(negedge mdc); event_in = 8'h04;
    @(negedge mdc); event_in = 8'h00;
    chk("R12 masked event no irq", {15'b0, irq}, 16'h0);
    event_in = 8'h01;
    @(negedge mdc); event_in = 8'h00;
    chk("R12 enabled event irq", {15'b0, irq}, 16'h1);
    rd_chk("R12 event word", 5'd17, 16'h0305);
    chk("R12 irq cleared by read", {15'b0, irq}, 16'h0);
    rd_chk("R12 events cleared", 5'd17, 16'h0300);

    // R5 R7 strap 10M only
    do_reset(3'b001);
    rd_chk("R5 reset 10M strap", 5'd0, f_ctrl(0, 0, 1, 0, 0, 0));
    rd_chk("R7 status 10M strap", 5'd1, f_status(3'b001, 1'b1));
    sp = f_spd(1'b0, 1'b1, 3'b001);
    mdio_wr(PHY, 5'd0, f_ctrl(0, 1, 0, 0, 0, 0));
    rd_chk("R5 100M write blocked", 5'd0, f_ctrl(0, sp, 0, 0, 0, 0));

    // R5 strap 100M only
    do_reset(3'b010);
    rd_chk("R7 status 100M strap", 5'd1, f_status(3'b010, 1'b1));
    sp = f_spd(1'b1, 1'b0, 3'b010);
    mdio_wr(PHY, 5'd0, f_ctrl(0, 0, 0, 0, 0, 0));
    rd_chk("R5 10M write blocked", 5'd0, f_ctrl(0, sp, 0, 0, 0, 0));
    chk("R6 manual 100M", {15'b0, speed_100}, 16'h1);

    exp = 16'h0; rv = exp; d = rv;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule